// File: doc/BRIEF.md
# Memory-Card Slot Status Register Block

This block is a small word-addressed register file that sits beside a memory-card slot. Software reads an identification word, a flash-programming word and a decode word from it. It also reads one status word that carries two card signals. The write-protect signal from the slot appears in the status word as a live level. The card-inserted signal is captured as an event and held until software clears it.

Both slot signals are asynchronous, so each passes through a two-flop synchronizer. A rising edge of the synchronized card-inserted signal sets a sticky event bit. That bit drives the interrupt output directly. Software clears the event by writing the status word with the event bit set to one. If a new edge arrives in the same cycle as a clearing write, the edge wins.

Every access is a single-cycle request. Each request gets a registered response one cycle later. The response carries read data and an error flag for offsets that are not mapped.

Top module: `card_slot_status`

## Requirements
- R1: After reset, `irq_o` is 0 and `rsp_vld_o` is 0. With both slot inputs low, the status word (index 2) reads 0.
- R2: A read of index 0 returns parameter `ID_VALUE`. A read of index 1 returns 0. A read of index 3 returns parameter `DECODE_VALUE`. None of these reads flags an error.
- R3: Status bit 0 reflects `wp_i` through a two-flop synchronizer. A read sampled at clock edge e shows the value `wp_i` had at edge e-2.
- R4: Status bit 3 is set by a rising edge of the synchronized `card_in_i`. For a read or edge at edge e, the bit is set when `card_in_i` was 1 at edge e-2 and 0 at edge e-3. The bit stays set after `card_in_i` falls. A level held high does not set the bit again after it is cleared.
- R5: `irq_o` equals status bit 3 at all times.
- R6: A write to index 2 whose data has bit 3 at 1 clears status bit 3. A write to index 2 with data bit 3 at 0 changes nothing, and status bit 0 cannot be written.
- R7: If a rising edge and a clearing write occur at the same edge, status bit 3 is 1 afterwards.
- R8: Writes to index 1 and index 3 get a response without error and change no state.
- R9: A read of any index above 3, or a write to index 0 or to any index above 3, gets a response with `rsp_err_o` set to 1 and read data 0.
- R10: Status bits other than 0 and 3 read as 0.
- R11: `rsp_vld_o` is 1 exactly in the cycle after each cycle with `req_i` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| wr_i | input | 1 | 1 = write, 0 = read |
| idx_i | input | IDX_W | Word index |
| wdata_i | input | DATA_W | Write data |
| wp_i | input | 1 | Write-protect level from the slot (asynchronous) |
| card_in_i | input | 1 | Card-inserted level from the slot (asynchronous) |
| rsp_vld_o | output | 1 | Response valid, one cycle after a request |
| rsp_err_o | output | 1 | Response is for an unmapped or read-only offset |
| rsp_rdata_o | output | DATA_W | Read data, 0 for writes and errors |
| irq_o | output | 1 | Card-inserted interrupt |

## Verification
The assertions assume the reset is held low for at least one clock edge with `req_i` low. This lets the checks that look one cycle back see a quiet bus when they start. They also assume that request fields are stable across the sampling edge. The bench therefore changes every input only on the falling clock edge. The bench drives the slot inputs as plain levels, also changed on the falling edge. This keeps the synchronizer latency fixed at exactly two edges, so the reference model can predict status bits cycle by cycle. It lines up one card-inserted edge with a clearing write to reach the set-wins case on purpose.

// File: rtl/cslot_pkg.sv
package cslot_pkg;
  localparam int unsigned WP_POS  = 0;
  localparam int unsigned INS_POS = 3;

  typedef enum logic [1:0] {
    IDX_IDENT  = 2'd0,
    IDX_FLASH  = 2'd1,
    IDX_STAT   = 2'd2,
    IDX_DECODE = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/cslot_sync.sv
module cslot_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = d_i;
    end else begin : g_rest
      always_comb stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cslot_evt.sv
module cslot_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic clr_i,
  output logic flag_o
);
  logic lvl_q;
  logic flag_q, flag_d;
  logic rise;

  assign rise = level_i & ~lvl_q;

  always_comb begin
    flag_d = flag_q;
    if (rise)       flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      lvl_q  <= level_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i && !lvl_q && clr_i) |=> flag_q);
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
  // R6
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(level_i && !lvl_q)) |=> !flag_q);
endmodule

// File: rtl/cslot_bus.sv
module cslot_bus
  import cslot_pkg::*;
#(
  parameter int unsigned       DATA_W       = 32,
  parameter int unsigned       IDX_W        = 4,
  parameter logic [DATA_W-1:0] ID_VALUE     = '0,
  parameter logic [DATA_W-1:0] DECODE_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] status_i,
  output logic              clr_o,
  output logic              rsp_vld_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  localparam logic [DATA_W-1:0] CLR_MASK = DATA_W'(1) << INS_POS;
  localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(IDX_DECODE);

  logic              mapped;
  logic [1:0]        sel;
  logic              vld_d, vld_q;
  logic              err_d, err_q;
  logic [DATA_W-1:0] rdata_d, rdata_q;

  assign mapped = (idx_i <= IDX_LAST);
  assign sel    = idx_i[1:0];
  assign clr_o  = req_i & wr_i & mapped & (reg_idx_e'(sel) == IDX_STAT)
                & (|(wdata_i & CLR_MASK));

  always_comb begin
    vld_d   = req_i;
    err_d   = 1'b0;
    rdata_d = '0;
    if (req_i) begin
      if (!mapped) begin
        err_d = 1'b1;
      end else if (wr_i) begin
        err_d = (reg_idx_e'(sel) == IDX_IDENT);
      end else begin
        unique case (reg_idx_e'(sel))
          IDX_IDENT:  rdata_d = ID_VALUE;
          IDX_FLASH:  rdata_d = '0;
          IDX_STAT:   rdata_d = status_i;
          IDX_DECODE: rdata_d = DECODE_VALUE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      vld_q   <= vld_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign rsp_vld_o   = vld_q;
  assign rsp_err_o   = err_q;
  assign rsp_rdata_o = rdata_q;

  // R11
  vld_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> rsp_vld_o);
  // R11
  no_spurious_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !rsp_vld_o);
  // R9
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err_o |-> (rsp_rdata_o == '0));
endmodule

// File: rtl/card_slot_status.sv
module card_slot_status
  import cslot_pkg::*;
#(
  parameter int unsigned       DATA_W       = 32,
  parameter int unsigned       IDX_W        = 4,
  parameter int unsigned       SYNC_STAGES  = 2,
  parameter logic [DATA_W-1:0] ID_VALUE     = 32'h5C0D_0A17,
  parameter logic [DATA_W-1:0] DECODE_VALUE = 32'h0000_0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wp_i,
  input  logic              card_in_i,
  output logic              rsp_vld_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              irq_o
);
  logic [1:0]        slot_s;
  logic              ins_flag;
  logic              clr;
  logic [DATA_W-1:0] status;

  cslot_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({card_in_i, wp_i}),
    .q_o   (slot_s)
  );

  cslot_evt u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (slot_s[1]),
    .clr_i   (clr),
    .flag_o  (ins_flag)
  );

  always_comb begin
    status          = '0;
    status[WP_POS]  = slot_s[0];
    status[INS_POS] = ins_flag;
  end

  cslot_bus #(
    .DATA_W       (DATA_W),
    .IDX_W        (IDX_W),
    .ID_VALUE     (ID_VALUE),
    .DECODE_VALUE (DECODE_VALUE)
  ) u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .wr_i        (wr_i),
    .idx_i       (idx_i),
    .wdata_i     (wdata_i),
    .status_i    (status),
    .clr_o       (clr),
    .rsp_vld_o   (rsp_vld_o),
    .rsp_err_o   (rsp_err_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  assign irq_o = ins_flag;

  // R5
  irq_matches_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !wr_i && idx_i == IDX_W'(2)) |=> (rsp_rdata_o[INS_POS] == $past(irq_o)));
  // R10
  stat_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !wr_i && idx_i == IDX_W'(2)) |=>
      ((rsp_rdata_o & ~((DATA_W'(1) << INS_POS) | (DATA_W'(1) << WP_POS))) == '0));
endmodule

// File: tb/sim_card_slot_status.sv
module sim_card_slot_status;
  localparam int DW = 32;
  localparam int IW = 4;
  localparam logic [DW-1:0] ID_V  = 32'hA1B2_C3D4;
  localparam logic [DW-1:0] DEC_V = 32'h0000_0055;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0, wp = 1'b0, cin = 1'b0;
  logic [IW-1:0] idx = '0;
  logic [DW-1:0] wdata = '0;
  logic vld, err, irq;
  logic [DW-1:0] rdata;

  int checks = 0, fails = 0, cycles = 0;
  string cur_tag = "R1";
  string m_tag = "R1";

  always #2.5 clk = ~clk;

  card_slot_status #(.DATA_W(DW), .IDX_W(IW), .ID_VALUE(ID_V), .DECODE_VALUE(DEC_V)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .idx_i(idx), .wdata_i(wdata),
    .wp_i(wp), .card_in_i(cin), .rsp_vld_o(vld), .rsp_err_o(err),
    .rsp_rdata_o(rdata), .irq_o(irq));

  // reference model: input histories, sticky flag, expected response
  logic wq1, wq2, iq1, iq2, iq3, m_flag, m_vld, m_err;
  logic [DW-1:0] m_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {wq1, wq2, iq1, iq2, iq3, m_flag, m_vld, m_err} <= '0;
      m_rdata <= '0;
    end else begin
      logic [DW-1:0] st;
      logic rise, clear;
      st = '0; st[0] = wq2; st[3] = m_flag;
      rise  = iq2 && !iq3;
      clear = req && wr && idx == 2 && wdata[3];
      m_vld <= req; m_err <= 1'b0; m_rdata <= '0; m_tag <= cur_tag;
      if (req) begin
        if (idx > 3 || (wr && idx == 0)) m_err <= 1'b1;
        else if (!wr) begin
          case (idx)
            0: m_rdata <= ID_V;
            1: m_rdata <= '0;
            2: m_rdata <= st;
            default: m_rdata <= DEC_V;
          endcase
        end
      end
      if (rise) m_flag <= 1'b1;
      else if (clear) m_flag <= 1'b0;
      wq2 <= wq1; wq1 <= wp;
      iq3 <= iq2; iq2 <= iq1; iq1 <= cin;
    end
  end

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cycles++;
    check("R5 irq", DW'(irq), DW'(m_flag));
    check("R11 rsp_vld", DW'(vld), DW'(m_vld));
    if (m_vld) begin
      check({m_tag, " err"}, DW'(err), DW'(m_err));
      check({m_tag, " rdata"}, rdata, m_rdata);
    end
  end

  task automatic access(logic w, int i, logic [DW-1:0] d, string tag);
    @(negedge clk);
    cur_tag = tag; req = 1'b1; wr = w; idx = IW'(i); wdata = d;
    @(negedge clk);
    req = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", DW'(irq), '0);
    check("R1 vld", DW'(vld), '0);
    access(1'b0, 2, '0, "R1");
    access(1'b0, 0, '0, "R2");
    access(1'b0, 1, '0, "R2");
    access(1'b0, 3, '0, "R2");
    // R3 write protect live
    wp = 1'b1; idle(3);
    access(1'b0, 2, '0, "R3");
    wp = 1'b0;
    access(1'b0, 2, '0, "R3");
    access(1'b0, 2, '0, "R3");
    // R4 card insert latch, survives fall
    cin = 1'b1; idle(5);
    access(1'b0, 2, '0, "R4");
    check("R4 irq set", DW'(irq), DW'(1));
    cin = 1'b0; idle(5);
    access(1'b0, 2, '0, "R4");
    // R6 write without bit 3, then with bit 3
    access(1'b1, 2, 32'hFFFF_FFF7, "R6");
    access(1'b0, 2, '0, "R6");
    access(1'b1, 2, 32'h0000_0008, "R6");
    access(1'b0, 2, '0, "R6");
    check("R6 irq cleared", DW'(irq), '0);
    // R4 held level does not re-set
    cin = 1'b1; idle(5);
    access(1'b1, 2, 32'h8, "R4");
    idle(4);
    check("R4 no re-set", DW'(irq), '0);
    cin = 1'b0; idle(4);
    // R7 set wins: edge reaches latch at the same edge as the clearing write
    @(negedge clk); cin = 1'b1;
    @(negedge clk);
    access(1'b1, 2, 32'h8, "R7");
    check("R7 set wins", DW'(irq), DW'(1));
    access(1'b0, 2, '0, "R7");
    // R8 ignored writes
    access(1'b1, 1, 32'hFFFF_FFFF, "R8");
    access(1'b1, 3, 32'hFFFF_FFFF, "R8");
    access(1'b0, 2, '0, "R8");
    check("R8 irq kept", DW'(irq), DW'(1));
    // R9 bad accesses
    access(1'b1, 0, 32'h8, "R9");
    access(1'b0, 5, '0, "R9");
    access(1'b1, 9, 32'h8, "R9");
    access(1'b0, 15, '0, "R9");
    check("R9 irq kept", DW'(irq), DW'(1));
    // R10 and mixed traffic
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      wp  = $urandom_range(0, 1);
      if ($urandom_range(0, 7) == 0) cin = ~cin;
      req = $urandom_range(0, 1);
      wr  = $urandom_range(0, 1);
      idx = IW'($urandom_range(0, 5));
      wdata = $urandom;
      cur_tag = "R10";
    end
    @(negedge clk); req = 1'b0;
    idle(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule